// File: doc/BRIEF.md
# Segmented DAC Control Decoder

This block is the digital front end of a 10-bit segmented current-steering converter. It registers an input word and splits it into two parts. The low four bits drive binary-weighted current cells directly. The high six bits turn on a number of equally weighted unary cells. Those unary cells sit on an 8x8 grid, and one position of the grid is left unused.

The six-bit unary part is split into a three-bit row value and a three-bit column value. Each value is expanded into a seven-line thermometer code. Every grid cell then decides locally from these two codes whether it is on. Before the cells are driven, the logical cell order is scattered across the physical grid by a fixed permutation in both directions, which averages out gradient error.

The binary lines pass through padding registers so that they reach the output on the same clock edge as the unary lines. Every control line leaves the block as a registered true/complement pair.

Top module: `dac_seg_frontend`

## Requirements
- R1: A synchronous active-high reset clears every stage: all true outputs are low and all complement outputs are high.
- R2: A word present at `code_i` at rising edge t appears on the outputs right after edge t+2, on the binary and unary lines alike.
- R3: `bin_p_o[i]` equals bit i of the word for i = 0..3.
- R4: The number of high bits in `cell_p_o` equals the word's bits [9:4], read as an unsigned value from 0 to 63.
- R5: Let k be the word's bits [9:4]. The logical cell at row r = bits [9:7] position and column c is on exactly when 8*r + c < k. A row below the active row is full, and the active row fills from column 0 upward.
- R6: Physical slots 0..7 along each axis take logical switching orders 2,4,8,6,3,1,5,7 in turn. Logical row r and column c therefore sit at the slots whose order is r+1 and c+1. The cell drives `cell_p_o[8*row_slot + col_slot]`.
- R7: Slot 18 (row slot 2, column slot 2) holds logical cell (7,7) and is never enabled.
- R8: `bin_n_o` is always the bitwise inverse of `bin_p_o`, and `cell_n_o` is always the bitwise inverse of `cell_p_o`.
- R9: When bits [9:4] rise by one between consecutive output words, exactly one additional cell turns on, and no cell that was on turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| code_i | input | 10 | Input word |
| bin_p_o | output | 4 | Binary cell controls, true polarity |
| bin_n_o | output | 4 | Binary cell controls, complement |
| cell_p_o | output | 64 | Unary grid controls by physical slot, true polarity |
| cell_n_o | output | 64 | Unary grid controls by physical slot, complement |

## Verification
The bench sweeps all 1024 words in ascending order and compares every output cycle against a behavioural model that places cells through the switching sequence.

- **Row boundaries.** Words where the column value wraps from 7 to 0 test row completion. A wrong full-row test would drop or double a whole row at each boundary.
- **Full scale.** The top word checks that the idle slot stays off. An off-by-one decoder would light all 64 cells.
- **Latency.** A single jump from zero to full scale checks alignment. A binary path without padding would show its bits one edge before the unary cells.
- **Placement.** A swapped entry in the permutation moves the lit cells to the wrong slots even though the count stays correct. The per-bit comparison catches this.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int LSB_W   = 4;
    localparam int HALF_W  = 3;
    localparam int MSB_W   = 2 * HALF_W;
    localparam int CODE_W  = LSB_W + MSB_W;
    localparam int SIDE    = 1 << HALF_W;
    localparam int THERM_W = SIDE - 1;
    localparam int CELLS   = SIDE * SIDE;

    typedef logic [THERM_W-1:0] therm_t;

    typedef struct packed {
        logic [MSB_W-1:0] msb;
        logic [LSB_W-1:0] lsb;
    } code_t;

    typedef struct packed {
        therm_t row;
        therm_t col;
    } grid_t;

    // physical slot that holds the logical position k (0-based switching step)
    function automatic int slot_of_step(input int k);
        case (k)
            0:       return 5;
            1:       return 0;
            2:       return 4;
            3:       return 1;
            4:       return 6;
            5:       return 3;
            6:       return 7;
            default: return 2;
        endcase
    endfunction

    localparam int IDLE_SLOT = slot_of_step(SIDE-1) * SIDE + slot_of_step(SIDE-1);

endpackage

// File: rtl/dac_therm3.sv
module dac_therm3
    import dac_fe_pkg::*;
(
    input  logic [HALF_W-1:0] val_i,
    output therm_t            therm_o
);
    // line k-1 is high when the value reaches k
    for (genvar k = 1; k <= THERM_W; k++) begin : g_line
        assign therm_o[k-1] = (int'(val_i) >= k);
    end
endmodule

// File: rtl/dac_pipe_delay.sv
module dac_pipe_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [DEPTH+1];
    assign stage[0] = d_i;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i+1] <= '0;
            else     stage[i+1] <= stage[i];
        end
    end

    assign q_o = stage[DEPTH];
endmodule

// File: rtl/dac_cell_array.sv
module dac_cell_array
    import dac_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  grid_t            grid_i,
    output logic [CELLS-1:0] on_p_o,
    output logic [CELLS-1:0] on_n_o
);
    // ge[k] is high when the value is at least k, for k = 0..SIDE
    logic [SIDE:0] row_ge;
    logic [SIDE:0] col_ge;
    assign row_ge = {1'b0, grid_i.row, 1'b1};
    assign col_ge = {1'b0, grid_i.col, 1'b1};

    for (genvar r = 0; r < SIDE; r++) begin : g_row
        for (genvar c = 0; c < SIDE; c++) begin : g_col
            localparam int SLOT = slot_of_step(r) * SIDE + slot_of_step(c);
            logic cell_on;
            assign cell_on = row_ge[r+1] | (row_ge[r] & col_ge[c+1]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    on_p_o[SLOT] <= 1'b0;
                    on_n_o[SLOT] <= 1'b1;
                end else begin
                    on_p_o[SLOT] <= cell_on;
                    on_n_o[SLOT] <= ~cell_on;
                end
            end
        end
    end

    // R7
    idle_off_chk: assert property (@(posedge clk) disable iff (rst)
        !on_p_o[IDLE_SLOT] && on_n_o[IDLE_SLOT]);

    // R8
    cell_pair_chk: assert property (@(posedge clk) disable iff (rst)
        on_n_o == ~on_p_o);
endmodule

// File: rtl/dac_seg_frontend.sv
module dac_seg_frontend
    import dac_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic [LSB_W-1:0]  bin_p_o,
    output logic [LSB_W-1:0]  bin_n_o,
    output logic [CELLS-1:0]  cell_p_o,
    output logic [CELLS-1:0]  cell_n_o
);
    // stage 1: input capture
    code_t code_q;
    always_ff @(posedge clk) begin
        if (rst) code_q <= '0;
        else     code_q <= code_t'(code_i);
    end

    // stage 2: row / column thermometer codes
    grid_t grid_d, grid_q;
    dac_therm3 u_row (.val_i(code_q.msb[MSB_W-1:HALF_W]), .therm_o(grid_d.row));
    dac_therm3 u_col (.val_i(code_q.msb[HALF_W-1:0]),     .therm_o(grid_d.col));

    always_ff @(posedge clk) begin
        if (rst) grid_q <= '0;
        else     grid_q <= grid_d;
    end

    // binary path padding to match the decode stage
    logic [LSB_W-1:0] lsb_mid;
    dac_pipe_delay #(.W(LSB_W), .DEPTH(1)) u_pad (
        .clk(clk), .rst(rst), .d_i(code_q.lsb), .q_o(lsb_mid)
    );

    // stage 3: output latches
    always_ff @(posedge clk) begin
        if (rst) begin
            bin_p_o <= '0;
            bin_n_o <= '1;
        end else begin
            bin_p_o <= lsb_mid;
            bin_n_o <= ~lsb_mid;
        end
    end

    dac_cell_array u_cells (
        .clk(clk), .rst(rst), .grid_i(grid_q),
        .on_p_o(cell_p_o), .on_n_o(cell_n_o)
    );

    // R5
    row_therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ((grid_q.row & (grid_q.row + therm_t'(1))) == '0) &&
        ((grid_q.col & (grid_q.col + therm_t'(1))) == '0));

    // R4
    cell_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cell_p_o) == int'($past(code_q.msb, 2)));

    // R3
    bin_align_chk: assert property (@(posedge clk) disable iff (rst)
        bin_p_o == $past(code_q.lsb, 2));

    // R8
    bin_pair_chk: assert property (@(posedge clk) disable iff (rst)
        bin_n_o == ~bin_p_o);
endmodule

// File: tb/sim_dac_seg_frontend.sv
module sim_dac_seg_frontend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  code = '0;
    logic [3:0]  bin_p, bin_n;
    logic [63:0] cell_p, cell_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit armed = 1'b0;

    always #2 clk = ~clk;

    dac_seg_frontend u0 (
        .clk(clk), .rst(rst), .code_i(code),
        .bin_p_o(bin_p), .bin_n_o(bin_n),
        .cell_p_o(cell_p), .cell_n_o(cell_n)
    );

    int ord [8] = '{2, 4, 8, 6, 3, 1, 5, 7};

    function automatic logic [63:0] model_cells(input int k);
        logic [63:0] v = '0;
        for (int i = 0; i < k; i++) begin
            int rp = 0;
            int cp = 0;
            for (int p = 0; p < 8; p++) begin
                if (ord[p] == i / 8 + 1) rp = p;
                if (ord[p] == i % 8 + 1) cp = p;
            end
            v[rp * 8 + cp] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference pipeline: three register stages
    int m1 = 0, m2 = 0, m3 = 0;
    always @(posedge clk) begin
        if (rst) begin m1 <= 0; m2 <= 0; m3 <= 0; end
        else begin m1 <= int'(code); m2 <= m1; m3 <= m2; end
        armed <= 1'b1;
    end

    int          prev_k = 0;
    logic [63:0] prev_cells = '0;
    always @(negedge clk) begin
        if (armed && !done) begin
            int k;
            k = m3 / 16;
            check("R5_R6 cell placement", cell_p, model_cells(k));
            check("R4 cell count", 64'($countones(cell_p)), 64'(k));
            check("R3 binary lines", 64'(bin_p), 64'(m3 % 16));
            check("R8 pairs", {cell_n, 4'(bin_n)} , {~cell_p, 4'(~bin_p)});
            check("R7 idle slot", 64'({cell_p[18], cell_n[18]}), 64'b01);
            if (!rst && k == prev_k + 1) begin
                check("R9 one more cell", 64'($countones(cell_p & ~prev_cells)), 64'd1);
                check("R9 none dropped", prev_cells & ~cell_p, 64'd0);
            end
            prev_k = k;
            prev_cells = cell_p;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset true", {cell_p, 4'(bin_p)}, '0);
        check("R1 reset complement", {cell_n, 4'(bin_n)}, '1);
        rst = 1'b0;
        for (int c = 0; c < 1024; c++) begin
            code = 10'(c);
            @(negedge clk);
        end
        code = '0;
        repeat (4) @(negedge clk);
        // R2 latency: jump to full scale for one cycle
        code = 10'h3FF;
        @(negedge clk);
        code = '0;
        check("R2 after one edge", {cell_p, 4'(bin_p)}, '0);
        @(negedge clk);
        check("R2 after two edges", {cell_p, 4'(bin_p)}, '0);
        @(negedge clk);
        check("R2 after three edges unary", cell_p, model_cells(63));
        check("R2 after three edges binary", 64'(bin_p), 64'hF);
        // mixed patterns
        foreach (ord[i]) begin
            code = 10'((ord[i] * 131) % 1024);
            @(negedge clk);
        end
        code = 10'h2A5; @(negedge clk);
        code = 10'h15A; @(negedge clk);
        repeat (4) @(negedge clk);
        // R1 mid-run reset
        rst = 1'b1;
        code = 10'h3FF;
        @(negedge clk);
        check("R1 mid reset true", {cell_p, 4'(bin_p)}, '0);
        check("R1 mid reset complement", {cell_n, 4'(bin_n)}, '1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule